// File: doc/BRIEF.md
# Cache Controller Register Stub

This block is the register face of a level-2 cache controller that has no cache array behind it. Software written for a real controller can probe it, enable it, tune its latency and filter settings, and issue maintenance operations. The block keeps the settings software writes and returns a fixed identification word. Every maintenance operation reads back as already finished, so polling loops end at once.

The block sits on a simple 32-bit register bus with an address, a write strobe with data, and a read strobe. Read data is registered. Only the low twelve address bits are decoded, so the block fills a 4 KiB window and aliases above it. The cache-type word is not a plain constant. Each read ORs in a field taken from the auxiliary control register's way-size and associativity bits and keeps the result. An error pulse marks accesses to offsets that map to nothing.

Top module: `cc_reg_stub`

## Requirements
- R1: After reset:
  - control reads 0.
  - auxiliary control reads 0x02020000.
  - tag latency, data latency, filter start and filter end read 0.
  - cache-type reads 0x1C100100.
  - `rd_data` is 0 and `bad_access` is low.
- R2: Only `addr[11:0]` selects a register. Addresses that differ only above bit 11 reach the same register.
- R3: Offset 0x000 reads the constant 0x410000C8. A write there changes nothing and pulses `bad_access`.
- R4: The control register at offset 0x100 stores only bit 0 of a write. Its bits 31:1 read 0.
- R5: These offsets are full 32-bit read/write registers that read back what was last written:
  - 0x104: auxiliary control.
  - 0x108: tag latency.
  - 0x10C: data latency.
  - 0xC00: filter start.
  - 0xC04: filter end.
- R6: A read of offset 0x004 builds a 5-bit field F:
  - F[4:2] = auxiliary control bits 19:17.
  - F[1] = 0.
  - F[0] = auxiliary control bit 16.

  F is ORed into the stored cache-type word at bits 22:18 and at bits 10:6. The result is stored and returned. Bits once set stay set until reset. A write to 0x004 changes nothing and pulses `bad_access`.
- R7: Any access with offset in 0x730 to 0x7FF inclusive reads 0 and discards writes, without `bad_access`.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read 0 and discard writes, without `bad_access`.
- R9: Any offset not named in R3 to R8 reads 0 and discards writes. `bad_access` is high for exactly the one cycle after such an access and low after any other cycle.
- R10: Read data appears on `rd_data` in the cycle after `rd_en`. It holds its value through cycles without a read. Reads may be issued back to back. A write and a read never share a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W (32) | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |

## Verification
The hardest behaviour to reach from the ports is the cache-type accumulation. It only shows when auxiliary control is written with several way-size and associativity patterns and offset 0x004 is read after each one. One later pattern must clear bits that an earlier pattern set, which shows that the readback keeps old bits instead of following the live register. The stimulus walks through such a sequence while the bench keeps its own OR-accumulated copy of the word. The maintenance window is probed at its first and last offsets and just outside both ends, so a decode off by one shows up as a wrong `bad_access` value.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  localparam int unsigned DW      = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned NFULL   = 5;
  localparam int unsigned NQUIET  = 3;
  localparam int unsigned FLD_W   = 5;

  localparam logic [DW-1:0]    ID_WORD    = 32'h4100_00C8;
  localparam logic [OFF_W-1:0] OFF_ID     = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CTYPE  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX    = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAG    = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DAT    = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FLO    = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FHI    = 12'hC04;
  localparam logic [OFF_W-1:0] MAINT_LO   = 12'h730;
  localparam logic [OFF_W-1:0] MAINT_END  = 12'h800;
  localparam logic [OFF_W-1:0] QUIET_BASE = 12'hF40;
  localparam logic [OFF_W-1:0] QUIET_STEP = 12'h020;

  // bit positions used to build the cache-type overlay
  localparam int unsigned AUX_ASSOC_BIT = 16;
  localparam int unsigned AUX_WAY_LSB   = 17;
  localparam int unsigned CT_HI_LSB     = 18;
  localparam int unsigned CT_LO_LSB     = 6;

  typedef enum logic [3:0] {
    SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_AUX, SEL_TAG, SEL_DAT,
    SEL_FLO, SEL_FHI, SEL_QUIET, SEL_MAINT, SEL_BAD
  } sel_e;

  function automatic sel_e full_slot_sel(input int unsigned i);
    case (i)
      0:       return SEL_AUX;
      1:       return SEL_TAG;
      2:       return SEL_DAT;
      3:       return SEL_FLO;
      default: return SEL_FHI;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] quiet_off(input int unsigned i);
    return QUIET_BASE + OFF_W'(i) * QUIET_STEP;
  endfunction

  function automatic logic [DW-1:0] ctype_overlay(input logic [DW-1:0] aux);
    logic [FLD_W-1:0] fld;
    logic [DW-1:0]    m;
    fld = {aux[AUX_WAY_LSB+2:AUX_WAY_LSB], 1'b0, aux[AUX_ASSOC_BIT]};
    m = '0;
    m[CT_HI_LSB +: FLD_W] = fld;
    m[CT_LO_LSB +: FLD_W] = fld;
    return m;
  endfunction

endpackage

// File: rtl/ccs_decode.sv
module ccs_decode
  import ccs_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output sel_e             sel
);

  logic [NQUIET-1:0] quiet_hit;

  for (genvar g = 0; g < NQUIET; g++) begin : g_quiet
    assign quiet_hit[g] = (off == quiet_off(g));
  end

  always_comb begin
    if (off >= MAINT_LO && off < MAINT_END) begin
      sel = SEL_MAINT;
    end else if (|quiet_hit) begin
      sel = SEL_QUIET;
    end else begin
      case (off)
        OFF_ID:    sel = SEL_ID;
        OFF_CTYPE: sel = SEL_CTYPE;
        OFF_CTRL:  sel = SEL_CTRL;
        OFF_AUX:   sel = SEL_AUX;
        OFF_TAG:   sel = SEL_TAG;
        OFF_DAT:   sel = SEL_DAT;
        OFF_FLO:   sel = SEL_FLO;
        OFF_FHI:   sel = SEL_FHI;
        default:   sel = SEL_BAD;
      endcase
    end
  end

endmodule

// File: rtl/ccs_regs.sv
module ccs_regs
  import ccs_pkg::*;
#(
  parameter logic [DW-1:0] AUX_RST   = 32'h0202_0000,
  parameter logic [DW-1:0] CTYPE_RST = 32'h1C10_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  sel_e          sel,
  input  logic [DW-1:0] wr_data,
  output logic          ctrl_bit,
  output logic [DW-1:0] aux_q,
  output logic [DW-1:0] tag_q,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] flo_q,
  output logic [DW-1:0] fhi_q,
  output logic [DW-1:0] ctype_view
);

  logic [NFULL-1:0][DW-1:0] full_q;

  for (genvar g = 0; g < NFULL; g++) begin : g_full
    localparam sel_e          SLOT = full_slot_sel(g);
    localparam logic [DW-1:0] RSTV = (g == 0) ? AUX_RST : '0;
    logic          we;
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    assign we = wr_en && (sel == SLOT);

    always_comb begin
      d = q;
      if (we) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RSTV;
      else        q <= d;
    end

    assign full_q[g] = q;
  end

  assign aux_q = full_q[0];
  assign tag_q = full_q[1];
  assign dat_q = full_q[2];
  assign flo_q = full_q[3];
  assign fhi_q = full_q[4];

  // control enable bit
  logic ctrl_d;
  always_comb begin
    ctrl_d = ctrl_bit;
    if (wr_en && sel == SEL_CTRL) ctrl_d = wr_data[0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_bit <= 1'b0;
    else        ctrl_bit <= ctrl_d;
  end

  // cache-type accumulator
  logic [DW-1:0] ctype_q;
  logic [DW-1:0] ctype_d;
  assign ctype_view = ctype_q | ctype_overlay(aux_q);
  always_comb begin
    ctype_d = ctype_q;
    if (rd_en && sel == SEL_CTYPE) ctype_d = ctype_view;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctype_q <= CTYPE_RST;
    else        ctype_q <= ctype_d;
  end

  // R6: stored cache-type bits never clear outside reset
  a_r6_ctype_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ctype_q & $past(ctype_q)) == $past(ctype_q)));

  // R5: auxiliary control changes only when written
  a_r5_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_AUX) |=> $stable(aux_q));

  // R4: control bit ignores reads and other offsets
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_CTRL) |=> $stable(ctrl_bit));

endmodule

// File: rtl/ccs_rdport.sv
module ccs_rdport
  import ccs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  sel_e          sel,
  input  logic          ctrl_bit,
  input  logic [DW-1:0] aux_q,
  input  logic [DW-1:0] tag_q,
  input  logic [DW-1:0] dat_q,
  input  logic [DW-1:0] flo_q,
  input  logic [DW-1:0] fhi_q,
  input  logic [DW-1:0] ctype_view,
  output logic [DW-1:0] rd_data,
  output logic          bad_access
);

  logic [DW-1:0] mux;
  logic [DW-1:0] rd_d;
  logic          bad_d;
  logic          ro_write;

  always_comb begin
    case (sel)
      SEL_ID:    mux = ID_WORD;
      SEL_CTYPE: mux = ctype_view;
      SEL_CTRL:  mux = {{(DW-1){1'b0}}, ctrl_bit};
      SEL_AUX:   mux = aux_q;
      SEL_TAG:   mux = tag_q;
      SEL_DAT:   mux = dat_q;
      SEL_FLO:   mux = flo_q;
      SEL_FHI:   mux = fhi_q;
      default:   mux = '0;
    endcase
  end

  assign ro_write = wr_en && (sel == SEL_ID || sel == SEL_CTYPE);

  always_comb begin
    rd_d = rd_data;
    if (rd_en) rd_d = mux;
    bad_d = ((rd_en || wr_en) && sel == SEL_BAD) || ro_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      bad_access <= 1'b0;
    end else begin
      rd_data    <= rd_d;
      bad_access <= bad_d;
    end
  end

  // R3: identification constant
  a_r3_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_ID) |=> (rd_data == ID_WORD));

  // R7: maintenance window reads zero and never errors
  a_r7_maint_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && sel == SEL_MAINT) |=> (!bad_access && (!$past(rd_en) || rd_data == '0)));

  // R8: quiet offsets never raise the error pulse
  a_r8_quiet_noerr: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && sel == SEL_QUIET) |=> !bad_access);

  // R9: error pulse only follows an access
  a_r9_pulse_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !bad_access);

  // R10: read data holds without a read
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R10: read and write never coincide
  a_r10_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

endmodule

// File: rtl/cc_reg_stub.sv
module cc_reg_stub
  import ccs_pkg::*;
#(
  parameter int unsigned   ADDR_W    = 32,
  parameter logic [DW-1:0] AUX_RST   = 32'h0202_0000,
  parameter logic [DW-1:0] CTYPE_RST = 32'h1C10_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              bad_access
);

  sel_e          sel;
  logic          ctrl_bit;
  logic [DW-1:0] aux_q, tag_q, dat_q, flo_q, fhi_q, ctype_view;

  // R2: address bits above the window are not decoded
  logic unused_addr_hi;
  assign unused_addr_hi = ^addr[ADDR_W-1:OFF_W];

  ccs_decode u_dec (
    .off (addr[OFF_W-1:0]),
    .sel (sel)
  );

  ccs_regs #(
    .AUX_RST   (AUX_RST),
    .CTYPE_RST (CTYPE_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .sel        (sel),
    .wr_data    (wr_data),
    .ctrl_bit   (ctrl_bit),
    .aux_q      (aux_q),
    .tag_q      (tag_q),
    .dat_q      (dat_q),
    .flo_q      (flo_q),
    .fhi_q      (fhi_q),
    .ctype_view (ctype_view)
  );

  ccs_rdport u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .sel        (sel),
    .ctrl_bit   (ctrl_bit),
    .aux_q      (aux_q),
    .tag_q      (tag_q),
    .dat_q      (dat_q),
    .flo_q      (flo_q),
    .fhi_q      (fhi_q),
    .ctype_view (ctype_view),
    .rd_data    (rd_data),
    .bad_access (bad_access)
  );

  // R4: control readback has only bit 0 live
  a_r4_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_CTRL) |=> (rd_data[DW-1:1] == '0));

endmodule

// File: tb/sim_cc_reg_stub.sv
module sim_cc_reg_stub;

  logic        clk;
  logic        rst_n;
  logic [31:0] addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        bad_access;

  int total;
  int bad;

  typedef struct {
    logic [31:0] d;
    bit          is_rd;
    bit          exp_bad;
    string       tag;
  } item_t;

  item_t q[$];

  logic [31:0] last_rd;
  logic [31:0] aux_m;
  logic [31:0] ctype_m;

  cc_reg_stub u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .bad_access (bad_access)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] overlay(input logic [31:0] a);
    logic [4:0]  f;
    logic [31:0] m;
    f = {a[19:17], 1'b0, a[16]};
    m = 32'h0;
    m[22:18] = f;
    m[10:6]  = f;
    return m;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one item per access, checks idle cycles too
  always @(posedge clk) begin
    bit act_seen;
    bit rd_seen;
    act_seen = (rd_en || wr_en) && rst_n;
    rd_seen  = rd_en;
    #1;
    if (rst_n) begin
      if (act_seen && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(bad_access == it.exp_bad, it.tag, "bad_access",
              {31'h0, bad_access}, {31'h0, it.exp_bad});
        if (rd_seen) begin
          check(rd_data == it.d, it.tag, "rd_data", rd_data, it.d);
          last_rd = it.d;
        end else begin
          check(rd_data == last_rd, it.tag, "rd_data held over write", rd_data, last_rd);
        end
      end else if (!act_seen) begin
        check(bad_access == 1'b0, "R9", "idle bad_access", {31'h0, bad_access}, 32'h0);
        check(rd_data == last_rd, "R10", "idle hold", rd_data, last_rd);
      end
    end
  end

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input bit eb, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0; wr_data = 32'h0;
    it.d = exp; it.is_rd = 1'b1; it.exp_bad = eb; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v, input bit eb, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; rd_en = 1'b0; wr_en = 1'b1; wr_data = v;
    if (a[11:0] == 12'h104) aux_m = v;
    it.d = 32'h0; it.is_rd = 1'b0; it.exp_bad = eb; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd_ctype(input string tag);
    ctype_m = ctype_m | overlay(aux_m);
    rd(32'h0000_0004, ctype_m, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    last_rd = 32'h0;
    aux_m = 32'h0202_0000;
    ctype_m = 32'h1C10_0100;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = 32'h0; wr_data = 32'h0;
    repeat (3) @(negedge clk);
    check(rd_data == 32'h0, "R1", "rd_data in reset", rd_data, 32'h0);
    check(bad_access == 1'b0, "R1", "bad_access in reset", {31'h0, bad_access}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R1 reset values
    rd(32'h100, 32'h0, 1'b0, "R1");
    rd(32'h104, 32'h0202_0000, 1'b0, "R1");
    rd(32'h108, 32'h0, 1'b0, "R1");
    rd(32'h10C, 32'h0, 1'b0, "R1");
    rd(32'hC00, 32'h0, 1'b0, "R1");
    rd(32'hC04, 32'h0, 1'b0, "R1");
    rd(32'h004, 32'h1C10_0100, 1'b0, "R1");
    idle(2);

    // R3 identification
    rd(32'h000, 32'h4100_00C8, 1'b0, "R3");
    wr(32'h000, 32'hFFFF_FFFF, 1'b1, "R3");
    rd(32'h000, 32'h4100_00C8, 1'b0, "R3");
    idle(1);

    // R4 control bit
    wr(32'h100, 32'hFFFF_FFFE, 1'b0, "R4");
    rd(32'h100, 32'h0, 1'b0, "R4");
    wr(32'h100, 32'hFFFF_FFFF, 1'b0, "R4");
    rd(32'h100, 32'h1, 1'b0, "R4");
    wr(32'h100, 32'h0000_0003, 1'b0, "R4");
    rd(32'h100, 32'h1, 1'b0, "R4");
    idle(1);

    // R5 full registers
    wr(32'h104, 32'hA5A5_5A5A, 1'b0, "R5");
    wr(32'h108, 32'h1234_5678, 1'b0, "R5");
    wr(32'h10C, 32'h8765_4321, 1'b0, "R5");
    wr(32'hC00, 32'hFFFF_0000, 1'b0, "R5");
    wr(32'hC04, 32'h0000_FFFF, 1'b0, "R5");
    rd(32'h104, 32'hA5A5_5A5A, 1'b0, "R5");
    rd(32'h108, 32'h1234_5678, 1'b0, "R5");
    rd(32'h10C, 32'h8765_4321, 1'b0, "R5");
    rd(32'hC00, 32'hFFFF_0000, 1'b0, "R5");
    rd(32'hC04, 32'h0000_FFFF, 1'b0, "R5");
    idle(2);

    // R2 aliasing above bit 11
    wr(32'hABCD_5C00, 32'hCAFE_F00D, 1'b0, "R2");
    rd(32'h0000_0C00, 32'hCAFE_F00D, 1'b0, "R2");
    rd(32'h1234_5104, 32'hA5A5_5A5A, 1'b0, "R2");
    rd(32'hFFFF_F000, 32'h4100_00C8, 1'b0, "R2");
    idle(1);

    // R6 cache-type accumulation
    rd_ctype("R6");
    wr(32'h104, 32'h000F_0000, 1'b0, "R6");
    rd_ctype("R6");
    check(ctype_m == 32'h1C74_0740, "R6", "model sanity", ctype_m, 32'h1C74_0740);
    wr(32'h104, 32'h0000_0000, 1'b0, "R6");
    rd_ctype("R6");
    rd_ctype("R6");
    wr(32'h004, 32'h0000_0000, 1'b1, "R6");
    rd_ctype("R6");
    idle(2);

    // R7 maintenance window and its edges
    wr(32'h730, 32'hFFFF_FFFF, 1'b0, "R7");
    wr(32'h7FC, 32'hFFFF_FFFF, 1'b0, "R7");
    rd(32'h730, 32'h0, 1'b0, "R7");
    rd(32'h7FF, 32'h0, 1'b0, "R7");
    rd(32'h72C, 32'h0, 1'b1, "R7");
    rd(32'h800, 32'h0, 1'b1, "R7");
    rd(32'h104, 32'h0, 1'b0, "R7");
    idle(1);

    // R8 quiet offsets
    wr(32'hF40, 32'h1, 1'b0, "R8");
    wr(32'hF60, 32'h1, 1'b0, "R8");
    wr(32'hF80, 32'h1, 1'b0, "R8");
    rd(32'hF40, 32'h0, 1'b0, "R8");
    rd(32'hF60, 32'h0, 1'b0, "R8");
    rd(32'hF80, 32'h0, 1'b0, "R8");
    rd(32'hF44, 32'h0, 1'b1, "R8");
    idle(1);

    // R9 unmapped offsets
    wr(32'h108, 32'h0BAD_BEEF, 1'b0, "R9");
    rd(32'h200, 32'h0, 1'b1, "R9");
    idle(1);
    wr(32'h110, 32'hFFFF_FFFF, 1'b1, "R9");
    idle(1);
    rd(32'h108, 32'h0BAD_BEEF, 1'b0, "R9");
    idle(1);

    // R10 back-to-back reads then hold
    rd(32'h000, 32'h4100_00C8, 1'b0, "R10");
    rd(32'h108, 32'h0BAD_BEEF, 1'b0, "R10");
    rd(32'hC00, 32'hCAFE_F00D, 1'b0, "R10");
    idle(4);

    wait (q.size() == 0);
    idle(2);
    summary();
    $finish;
  end

endmodule